// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital sequencer for an 8-bit, 8-input successive-approximation analog-to-digital converter. A start request latches three settings: the input to convert, a prescaler code and a halve bit. The conversion then runs on a converter clock enable, which a selectable divider derives from the system clock. Each conversion lasts a fixed number of converter periods. It begins with a sample window in which the input multiplexer select and the sample strobe are driven. A binary search over the result bits follows, MSB first. During the search the block drives a trial code toward the external DAC and reads back a one-bit comparator decision.

When the last period ends, the block loads the result register, sets a done flag and pulses an interrupt for one system clock. The analog parts (multiplexer, sample-and-hold, DAC, comparator) sit outside the block. A host pulses `start`, waits for `done` or `irq`, then reads `result`.

Top module: `adc_sar_ctrl`

## Requirements
- R1: With `halve`=0, one converter period lasts 2, 4 or 16 system clocks for `pre_sel` codes 00, 01 and 11.
- R2: With `halve`=1, one converter period lasts 1, 2 or 8 system clocks for `pre_sel` codes 00, 01 and 11.
- R3: `pre_sel` code 10 gives the same period as code 11.
- R4: An accepted start makes `busy` high for exactly 160 converter periods, starting on the clock edge that samples `start`. `sample_en` is high for the first 12 of those periods and never while idle.
- R5: `chan_sel`, `pre_sel` and `halve` are captured when a start is accepted. `mux_sel` shows the captured channel and stays stable for the whole conversion.
- R6: After sampling, 8 bit trials of 18 periods each run MSB first, followed by a 4-period tail. During a trial, `trial_code` is the bits kept so far with the trial bit set, so the first trial code is 8'h80. A trial bit is kept when `cmp_in` is 1, meaning the input is at or above the trial level. With an ideal comparator, `result` equals the input code.
- R7: A start pulse while `busy` is high is ignored. The running conversion keeps its channel, its timing and its outcome.
- R8: `done` is set when a conversion completes and is cleared on the edge that accepts the next start. `irq` is high for exactly one clock at each completion.
- R9: `result` changes only at a conversion's completion and holds its value between completions, including throughout a later conversion.
- R10: After reset, `busy`, `done`, `irq`, `sample_en` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, accepted when idle |
| chan_sel | input | 3 | Input channel to convert |
| pre_sel | input | 2 | Prescaler code |
| halve | input | 1 | 1 selects the halved divide ratios |
| cmp_in | input | 1 | Comparator: 1 when input is at or above `trial_code` |
| mux_sel | output | 3 | Captured channel toward the analog multiplexer |
| sample_en | output | 1 | Sample-and-hold strobe |
| trial_code | output | 8 | Code driven to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Conversion complete flag |
| irq | output | 1 | One-clock completion interrupt |
| result | output | 8 | Last conversion result |

## Verification
The assertions assume that `cmp_in` is settled whenever a trial decision is taken. They also assume that `start` is a clean synchronous level, so an accepted start can only arrive from the idle state. The bench drives the comparator as a combinational ideal threshold between a per-channel target code and `trial_code`. All inputs change on the falling clock edge, so every decision sees a stable comparator value. Start pulses are one clock wide, and the one given mid-conversion checks that the block ignores a request while busy.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;

  localparam int RES_W    = 8;
  localparam int NUM_CH   = 8;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int CONV_CYC = 160;
  localparam int SAMP_CYC = 12;
  localparam int MAX_DIV  = 16;
  localparam int DIV_W    = $clog2(MAX_DIV + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SAMP  = 2'd1,
    ST_TRIAL = 2'd2,
    ST_TAIL  = 2'd3
  } sar_state_e;

  // Converter period in system clocks for a prescaler code and halve bit.
  // Reserved code 2'b10 falls back to the slowest setting.
  function automatic logic [DIV_W-1:0] div_ratio(input logic [1:0] pre, input logic halve);
    logic [DIV_W-1:0] base;
    case (pre)
      2'b00:   base = DIV_W'(2);
      2'b01:   base = DIV_W'(4);
      default: base = DIV_W'(16);
    endcase
    return halve ? (base >> 1) : base;
  endfunction

endpackage

// File: rtl/adc_clkdiv.sv
module adc_clkdiv
  import adc_sar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       run,
  input  logic [1:0] pre,
  input  logic       halve,
  output logic       tick
);

  logic [DIV_W-1:0] ratio_q;
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == ratio_q - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= DIV_W'(2);
      cnt_q   <= '0;
    end else if (load) begin
      ratio_q <= div_ratio(pre, halve);
      cnt_q   <= '0;
    end else if (run) begin
      cnt_q <= tick ? '0 : cnt_q + DIV_W'(1);
    end else begin
      cnt_q <= '0;
    end
  end

  // R1 R2: divider count never leaves the range of the captured ratio
  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < ratio_q));

  // R3: captured ratio is always one of the legal periods
  a_r3_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q == 1) || (ratio_q == 2) || (ratio_q == 4) || (ratio_q == 8) || (ratio_q == 16));

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_sar_pkg::*;
#(
  parameter int RES   = RES_W,
  parameter int CONV  = CONV_CYC,
  parameter int SAMP  = SAMP_CYC
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_acc,
  input  logic           tick,
  input  logic           cmp_in,
  output logic           busy,
  output logic           sample_en,
  output logic [RES-1:0] trial_code,
  output logic           conv_end,
  output logic [RES-1:0] acc_final
);

  localparam int TRIAL_CYC = (CONV - SAMP) / RES;
  localparam int TAIL_CYC  = CONV - SAMP - RES * TRIAL_CYC;
  localparam int PER_W     = $clog2(CONV);
  localparam int SUB_W     = $clog2(TRIAL_CYC + SAMP + 1);
  localparam int BIT_W     = (RES > 1) ? $clog2(RES) : 1;

  sar_state_e       state_q;
  logic [PER_W-1:0] per_q;
  logic [SUB_W-1:0] sub_q;
  logic [BIT_W-1:0] bit_q;
  logic [RES-1:0]   acc_q;
  logic [RES-1:0]   bit_mask;
  logic [RES-1:0]   acc_next;
  logic             samp_last, trial_last, tail_last, last_bit;

  assign bit_mask   = RES'(1) << bit_q;
  assign acc_next   = cmp_in ? (acc_q | bit_mask) : (acc_q & ~bit_mask);
  assign samp_last  = (sub_q == SUB_W'(SAMP - 1));
  assign trial_last = (sub_q == SUB_W'(TRIAL_CYC - 1));
  assign tail_last  = (sub_q == SUB_W'(TAIL_CYC - 1));
  assign last_bit   = (bit_q == '0);

  assign busy       = (state_q != ST_IDLE);
  assign sample_en  = (state_q == ST_SAMP);
  assign trial_code = (state_q == ST_TRIAL) ? (acc_q | bit_mask) : acc_q;

  always_comb begin
    conv_end = 1'b0;
    if (tick) begin
      if (state_q == ST_TAIL && tail_last) conv_end = 1'b1;
      if (state_q == ST_TRIAL && trial_last && last_bit && TAIL_CYC == 0) conv_end = 1'b1;
    end
  end

  assign acc_final = (state_q == ST_TRIAL) ? acc_next : acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      per_q   <= '0;
      sub_q   <= '0;
      bit_q   <= '0;
      acc_q   <= '0;
    end else if (start_acc) begin
      state_q <= ST_SAMP;
      per_q   <= '0;
      sub_q   <= '0;
      bit_q   <= BIT_W'(RES - 1);
      acc_q   <= '0;
    end else if (tick) begin
      per_q <= per_q + PER_W'(1);
      case (state_q)
        ST_SAMP: begin
          if (samp_last) begin
            state_q <= ST_TRIAL;
            sub_q   <= '0;
          end else begin
            sub_q <= sub_q + SUB_W'(1);
          end
        end
        ST_TRIAL: begin
          if (trial_last) begin
            acc_q <= acc_next;
            sub_q <= '0;
            if (last_bit) begin
              state_q <= (TAIL_CYC == 0) ? ST_IDLE : ST_TAIL;
            end else begin
              bit_q <= bit_q - BIT_W'(1);
            end
          end else begin
            sub_q <= sub_q + SUB_W'(1);
          end
        end
        ST_TAIL: begin
          if (tail_last) state_q <= ST_IDLE;
          else           sub_q   <= sub_q + SUB_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: completion coincides with the last of the fixed converter periods
  a_r4_end_on_last_period: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |-> (per_q == PER_W'(CONV - 1)));

  // R4: sampling window only in the opening periods
  a_r4_samp_early: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (per_q < PER_W'(SAMP)));

  // R6: bits at and below the current trial position are still clear
  a_r6_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRIAL) |-> ((acc_q & ((bit_mask << 1) - RES'(1))) == '0));

  // R6: trial position only moves downward, one step per trial
  a_r6_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRIAL && $past(state_q) == ST_TRIAL && !$stable(bit_q))
      |-> (bit_q == $past(bit_q) - BIT_W'(1)));

endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
  import adc_sar_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic [1:0]       pre_sel,
  input  logic             halve,
  input  logic             cmp_in,
  output logic [CH_W-1:0]  mux_sel,
  output logic             sample_en,
  output logic [RES_W-1:0] trial_code,
  output logic             busy,
  output logic             done,
  output logic             irq,
  output logic [RES_W-1:0] result
);

  logic             start_acc;
  logic             tick;
  logic             conv_end;
  logic [RES_W-1:0] acc_final;
  logic [CH_W-1:0]  chan_q;

  assign start_acc = start && !busy;
  assign mux_sel   = chan_q;

  adc_clkdiv u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_acc),
    .run   (busy),
    .pre   (pre_sel),
    .halve (halve),
    .tick  (tick)
  );

  adc_sar_core #(
    .RES  (RES_W),
    .CONV (CONV_CYC),
    .SAMP (SAMP_CYC)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_acc  (start_acc),
    .tick       (tick),
    .cmp_in     (cmp_in),
    .busy       (busy),
    .sample_en  (sample_en),
    .trial_code (trial_code),
    .conv_end   (conv_end),
    .acc_final  (acc_final)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      done   <= 1'b0;
      irq    <= 1'b0;
      result <= '0;
    end else begin
      irq <= conv_end;
      if (start_acc) begin
        chan_q <= chan_sel;
        done   <= 1'b0;
      end else if (conv_end) begin
        done   <= 1'b1;
        result <= acc_final;
      end
    end
  end

  // R9: result only moves on the completion edge
  a_r9_result_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> irq);

  // R8: interrupt is a single-clock pulse
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R8: done flag never overlaps a running conversion
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5 R7: channel select held for the whole conversion
  a_r5_mux_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mux_sel));

endmodule

// File: tb/test_adc_sar_ctrl.sv
module test_adc_sar_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] chan_sel = '0;
  logic [1:0] pre_sel = '0;
  logic       halve = 1'b0;
  logic       cmp_in;
  logic [2:0] mux_sel;
  logic       sample_en;
  logic [7:0] trial_code;
  logic       busy, done, irq;
  logic [7:0] result;

  logic [7:0] tgt [8];
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  // ideal comparator: input at or above trial level
  assign cmp_in = (tgt[mux_sel] >= trial_code);

  adc_sar_ctrl i_adc_sar_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .pre_sel(pre_sel), .halve(halve), .cmp_in(cmp_in), .mux_sel(mux_sel),
    .sample_en(sample_en), .trial_code(trial_code), .busy(busy),
    .done(done), .irq(irq), .result(result)
  );

  // {chan[3], pre[2], halve[1], target[8]}
  localparam logic [13:0] VEC [9] = '{
    {3'd0, 2'b00, 1'b0, 8'h00},
    {3'd1, 2'b01, 1'b0, 8'hFF},
    {3'd2, 2'b11, 1'b0, 8'h80},
    {3'd3, 2'b00, 1'b1, 8'h7F},
    {3'd4, 2'b01, 1'b1, 8'h55},
    {3'd5, 2'b11, 1'b1, 8'hAA},
    {3'd6, 2'b10, 1'b0, 8'h01},
    {3'd7, 2'b10, 1'b1, 8'hFE},
    {3'd0, 2'b00, 1'b1, 8'h3C}
  };

  function automatic int exp_period(input logic [1:0] p, input logic h);
    int slow;
    slow = (p == 2'b00) ? 2 : (p == 2'b01) ? 4 : 16;
    return h ? slow / 2 : slow;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // runs one conversion and checks timing, trial code, result and flags
  task automatic run_conv(input logic [2:0] ch, input logic [1:0] p,
                          input logic h, input logic [7:0] t, input string tag);
    int busy_n = 0, samp_n = 0, mux_bad = 0, irq_n = 0, guard = 0;
    int first_tr = -1;
    int per = exp_period(p, h);
    chan_sel = ch; pre_sel = p; halve = h; tgt[ch] = t;
    pulse_start();
    while (busy && guard < 5000) begin
      busy_n++;
      if (sample_en) samp_n++;
      else if (first_tr < 0) first_tr = trial_code;
      if (mux_sel != ch) mux_bad++;
      if (irq) irq_n++;
      guard++;
      @(negedge clk);
    end
    chk({tag, " busy length"}, busy_n, 160 * per);
    chk("R4 sample length", samp_n, 12 * per);
    chk("R5 mux held", mux_bad, 0);
    chk("R6 first trial code", first_tr, 8'h80);
    chk("R6 result", result, t);
    chk("R8 done set", done, 1);
    for (int k = 0; k < 3; k++) begin
      if (irq) irq_n++;
      @(negedge clk);
    end
    chk("R8 irq single", irq_n, 1);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int bl;
    for (int i = 0; i < 8; i++) tgt[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 irq", irq, 0);
    chk("R10 sample_en", sample_en, 0);
    chk("R10 result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 9; v++) begin
      logic [1:0] p;
      logic h;
      p = VEC[v][10:9];
      h = VEC[v][8];
      run_conv(VEC[v][13:11], p, h, VEC[v][7:0],
               (p == 2'b10) ? "R3" : (h ? "R2" : "R1"));
    end

    // R7: start during busy is ignored
    chan_sel = 3'd3; pre_sel = 2'b00; halve = 1'b1; tgt[3] = 8'h11; tgt[5] = 8'hEE;
    pulse_start();
    bl = 1;
    repeat (50) begin @(negedge clk); bl++; end
    chan_sel = 3'd5; pre_sel = 2'b11; halve = 1'b0;
    start = 1'b1;
    @(negedge clk); bl++;
    start = 1'b0;
    chk("R7 mux unchanged", mux_sel, 3);
    while (busy && bl < 5000) begin @(negedge clk); bl++; end
    chk("R7 length unchanged", bl - 1, 160);
    chk("R7 result of first channel", result, 8'h11);

    // R8 done clears on next accepted start; R9 result holds meanwhile
    chk("R8 done before restart", done, 1);
    chan_sel = 3'd5; pre_sel = 2'b01; halve = 1'b1;
    pulse_start();
    chk("R8 done cleared", done, 0);
    chk("R8 busy after restart", busy, 1);
    repeat (200) @(negedge clk);
    chk("R9 result held mid-conversion", result, 8'h11);
    while (busy) @(negedge clk);
    chk("R9 result updated at end", result, 8'hEE);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule